// File: doc/BRIEF.md
# 64 kbit/s idle synchronization frame serializer

This block produces the idle downlink synchronization frame that a packet control unit sends to a channel codec unit over a whole 64 kbit/s timeslot. Each frame is 1280 bits long. It opens with a 64-bit run of zeros closed by a single one. A control field follows with its own parity bit. The data area carries a frame sequence number and two fixed one-bit markers that let the receiver regain alignment in the middle of a frame. A time-alignment tail closes the frame. The frame leaves the block as 160 octets, one on each pulse of an 8 kHz tick strobe. The first bit on the line is the octet MSB.

Software or a higher-level controller sets the time adjustment code and the uplink-error flag with a one-cycle start request. The first request starts transmission. From then on frames follow one another with no gap. A later request is held pending and takes effect only at the next frame boundary, so a frame never mixes old and new control values. A frame-start strobe marks the octet that begins each frame. The sequence number is kept inside the block and steps once per frame, so the far end can return it.

Top module: `pcu_sync64_tx`

## Requirements
- R1: The first eight octets of every frame are 0x00 (frame bits 0..63). Bit 64, the MSB of octet 8, is 1.
- R2: Frame bits 65..72 carry control bits C1..C8, with C1 first. C1..C5 are the FRAME_TYPE parameter, MSB first. C6..C7 are the time adjustment code (tav[1] then tav[0]: 00 hold, 01 delay 250 us, 10 advance 250 us). C8 is the uplink-error flag (0 = bad uplink frames seen, 1 = good). On the octets this is octet 8 bits 6..0 = C1..C7 and octet 9 bit 7 = C8.
- R3: Frame bit 73 (octet 9 bit 6) is an odd parity bit, so that C1..C8 together with it hold an odd number of ones.
- R4: Frame bits 74..81 carry the 8-bit sequence number, MSB first. On the octets this is octet 9 bits 5..0 = seq[7:2] and octet 10 bits 7..6 = seq[1:0]. The first frame after reset carries 0. Each later frame carries the previous value plus one, wrapping at 256.
- R5: The remaining data bits (from bit 82), the marker bits at positions 128 and 192, and the 16 time-alignment bits 1264..1279 are all 1. This makes octet 10 bits 5..0 and octets 11..159 equal to 0xFF.
- R6: The output octet changes only in the cycle after a tick. It holds its value between ticks. A frame is 160 consecutive ticked octets.
- R7: sof_o is high for exactly one cycle, together with octet 0 of each frame. Once transmission has begun, frames follow back to back, so sof_o recurs every 160 ticks.
- R8: Until the first start request, each tick outputs 0xFF and sof_o stays low. The first frame begins at the first tick after the cycle in which the request was sampled.
- R9: A start request made during a frame latches its tav/ufe values, and they apply from the next frame boundary. The current frame keeps its values. The latest request before a boundary wins. A request sampled in the same cycle as a boundary tick applies at the following boundary.
- R10: While reset is asserted, octet_o is 0xFF and sof_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 8 kHz octet strobe, one cycle wide |
| start_i | input | 1 | Request to send frames with the given control values |
| tav_i | input | 2 | Time adjustment code sampled with start_i |
| ufe_i | input | 1 | Uplink-error flag sampled with start_i |
| octet_o | output | 8 | Current line octet, first bit in MSB |
| sof_o | output | 1 | One-cycle strobe with the first octet of a frame |

## Verification
The sync run, marker bits and filler are fixed in position. A misplaced octet index therefore shows as a wrong octet at the very next tick and, at the latest, as a sof_o pulse that is not exactly 160 ticks after the previous one. A wrong pending or active control register stays hidden until octets 8 and 9 of the next frame, which can be up to 169 ticks after the request. The bench therefore places requests both mid-frame and in the same cycle as a boundary tick. A sequence counter that skips or fails to wrap shows only in octets 9 and 10. For that reason the run spans more than 256 frames, so the wrap from 255 to 0 is observed.

// File: rtl/pcu_sync64_pkg.sv
package pcu_sync64_pkg;

    // frame geometry
    localparam int SYNC_ZEROS   = 64;
    localparam int CTRL_BITS    = 8;
    localparam int DATA_A_BITS  = 54;
    localparam int DATA_B_BITS  = 63;
    localparam int DATA_C_BITS  = 1071;
    localparam int TA_BITS      = 16;
    localparam int SEQ_BITS     = 8;
    localparam int FTYPE_BITS   = 5;
    localparam int TAV_BITS     = 2;
    localparam int OCTET_BITS   = 8;

    // derived bit positions (0 = first bit on the line)
    localparam int CTRL_POS     = SYNC_ZEROS + 1;
    localparam int PAR_POS      = CTRL_POS + CTRL_BITS;
    localparam int DATA_POS     = PAR_POS + 1;
    localparam int MARK1_POS    = DATA_POS + DATA_A_BITS;
    localparam int MARK2_POS    = MARK1_POS + 1 + DATA_B_BITS;
    localparam int TA_POS       = MARK2_POS + 1 + DATA_C_BITS;
    localparam int FRAME_BITS   = TA_POS + TA_BITS;
    localparam int FRAME_OCTETS = FRAME_BITS / OCTET_BITS;
    localparam int IDX_W        = $clog2(FRAME_OCTETS);
    localparam int CTRL_IW      = $clog2(CTRL_BITS);
    localparam int SEQ_IW       = $clog2(SEQ_BITS);

    typedef enum logic [TAV_BITS-1:0] {
        TAV_HOLD    = 2'b00,
        TAV_DELAY   = 2'b01,
        TAV_ADVANCE = 2'b10,
        TAV_RSVD    = 2'b11
    } tav_e;

    // C1 is the MSB of this struct
    typedef struct packed {
        logic [FTYPE_BITS-1:0] ftype;
        tav_e                  tav;
        logic                  ufe;
    } ctrl_t;

    // value of one line bit of the frame
    function automatic logic frame_bit(input int pos, input ctrl_t c,
                                       input logic par,
                                       input logic [SEQ_BITS-1:0] seq);
        logic [CTRL_BITS-1:0] cv;
        logic                 b;
        cv = c;
        b  = 1'b1;
        if (pos < SYNC_ZEROS) begin
            b = 1'b0;
        end else if (pos < CTRL_POS) begin
            b = 1'b1;
        end else if (pos < PAR_POS) begin
            b = cv[CTRL_IW'(CTRL_BITS - 1 - (pos - CTRL_POS))];
        end else if (pos == PAR_POS) begin
            b = par;
        end else if (pos < DATA_POS + SEQ_BITS) begin
            b = seq[SEQ_IW'(SEQ_BITS - 1 - (pos - DATA_POS))];
        end else if (pos == MARK1_POS || pos == MARK2_POS) begin
            b = 1'b1;
        end else if (pos >= TA_POS) begin
            b = 1'b1;
        end
        return b;
    endfunction

endpackage

// File: rtl/pcu_sync64_ctrl.sv
module pcu_sync64_ctrl
    import pcu_sync64_pkg::*;
#(
    parameter logic [FTYPE_BITS-1:0] FRAME_TYPE = 5'b10110
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [TAV_BITS-1:0] tav_i,
    input  logic                ufe_i,
    input  logic                boundary_i,
    output logic                pend_o,
    output ctrl_t               ctrl_o,
    output logic                par_o
);

    typedef struct packed {
        logic pend;
        tav_e ptav;
        logic pufe;
        tav_e atav;
        logic aufe;
    } cst_t;

    cst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (boundary_i && st_q.pend) begin
            st_d.atav = st_q.ptav;
            st_d.aufe = st_q.pufe;
            st_d.pend = 1'b0;
        end
        if (start_i) begin
            st_d.pend = 1'b1;
            st_d.ptav = tav_e'(tav_i);
            st_d.pufe = ufe_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{pend: 1'b0, ptav: TAV_HOLD, pufe: 1'b1,
                      atav: TAV_HOLD, aufe: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign ctrl_o = '{ftype: FRAME_TYPE, tav: st_q.atav, ufe: st_q.aufe};
    assign par_o  = ~(^ctrl_o);

endmodule

// File: rtl/pcu_sync64_seq.sv
module pcu_sync64_seq
    import pcu_sync64_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                boundary_i,
    output logic [SEQ_BITS-1:0] seq_o
);

    typedef struct packed {
        logic [SEQ_BITS-1:0] next;
        logic [SEQ_BITS-1:0] cur;
    } sst_t;

    sst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (boundary_i) begin
            st_d.cur  = st_q.next;
            st_d.next = st_q.next + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_o = st_q.cur;

endmodule

// File: rtl/pcu_sync64_octet.sv
module pcu_sync64_octet
    import pcu_sync64_pkg::*;
(
    input  logic [IDX_W-1:0]      idx_i,
    input  ctrl_t                 ctrl_i,
    input  logic                  par_i,
    input  logic [SEQ_BITS-1:0]   seq_i,
    output logic [OCTET_BITS-1:0] octet_o
);

    for (genvar g = 0; g < OCTET_BITS; g++) begin : g_bit
        always_comb begin
            octet_o[OCTET_BITS-1-g] =
                frame_bit(int'(idx_i) * OCTET_BITS + g, ctrl_i, par_i, seq_i);
        end
    end

endmodule

// File: rtl/pcu_sync64_tx.sv
module pcu_sync64_tx
    import pcu_sync64_pkg::*;
#(
    parameter logic [FTYPE_BITS-1:0] FRAME_TYPE = 5'b10110
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  tick_i,
    input  logic                  start_i,
    input  logic [TAV_BITS-1:0]   tav_i,
    input  logic                  ufe_i,
    output logic [OCTET_BITS-1:0] octet_o,
    output logic                  sof_o
);

    localparam logic [IDX_W-1:0]      LAST_IDX   = IDX_W'(FRAME_OCTETS - 1);
    localparam logic [OCTET_BITS-1:0] IDLE_OCTET = '1;

    typedef struct packed {
        logic                  run;
        logic [IDX_W-1:0]      idx;
        logic [OCTET_BITS-1:0] octet;
        logic                  sof;
    } tst_t;

    tst_t st_d, st_q;

    logic                  run_q;
    logic                  boundary;
    logic                  pend;
    ctrl_t                 ctrl_act;
    logic                  ctrl_par;
    logic [SEQ_BITS-1:0]   frame_seq;
    logic [OCTET_BITS-1:0] comp_octet;

    assign run_q = st_q.run;

    pcu_sync64_ctrl #(
        .FRAME_TYPE (FRAME_TYPE)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .tav_i      (tav_i),
        .ufe_i      (ufe_i),
        .boundary_i (boundary),
        .pend_o     (pend),
        .ctrl_o     (ctrl_act),
        .par_o      (ctrl_par)
    );

    pcu_sync64_seq u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .boundary_i (boundary),
        .seq_o      (frame_seq)
    );

    pcu_sync64_octet u_octet (
        .idx_i   (st_q.idx),
        .ctrl_i  (ctrl_act),
        .par_i   (ctrl_par),
        .seq_i   (frame_seq),
        .octet_o (comp_octet)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sof = 1'b0;
        boundary = 1'b0;
        if (tick_i) begin
            if (st_q.idx == '0) begin
                if (run_q || pend) begin
                    boundary   = 1'b1;
                    st_d.run   = 1'b1;
                    st_d.sof   = 1'b1;
                    st_d.octet = comp_octet;
                    st_d.idx   = IDX_W'(1);
                end else begin
                    st_d.octet = IDLE_OCTET;
                end
            end else begin
                st_d.octet = comp_octet;
                st_d.idx   = (st_q.idx == LAST_IDX) ? '0 : st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{run: 1'b0, idx: '0, octet: IDLE_OCTET, sof: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign octet_o = st_q.octet;
    assign sof_o   = st_q.sof;

endmodule

// File: rtl/pcu_sync64_chk.sv
module pcu_sync64_chk
    import pcu_sync64_pkg::*;
(
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  tick_i,
    input logic [OCTET_BITS-1:0] octet_o,
    input logic                  sof_o,
    input logic                  run_q,
    input logic                  boundary,
    input ctrl_t                 act_ctrl,
    input logic [SEQ_BITS-1:0]   frame_seq
);

    logic seen_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seen_q <= 1'b0;
        end else if (boundary) begin
            seen_q <= 1'b1;
        end
    end

    p_sof_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sof_o |-> (octet_o == '0));

    p_seq_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (boundary && seen_q) |=> (frame_seq == $past(frame_seq) + 8'd1));

    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(octet_o));

    p_sof_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sof_o |-> $past(tick_i));

    p_sof_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sof_o |=> !sof_o);

    p_idle_ones_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_q |-> (octet_o == '1));

    p_ctrl_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !boundary |=> $stable(act_ctrl));

endmodule

bind pcu_sync64_tx pcu_sync64_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .octet_o   (octet_o),
    .sof_o     (sof_o),
    .run_q     (run_q),
    .boundary  (boundary),
    .act_ctrl  (ctrl_act),
    .frame_seq (frame_seq)
);

// File: tb/pcu_sync64_tx_tb.sv
`timescale 1ns/1ps
module pcu_sync64_tx_tb;

    localparam logic [4:0] FT = 5'b01101;
    localparam int NBITS = 1280;
    localparam int NOCT  = 160;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       start = 1'b0;
    logic [1:0] tav = 2'b00;
    logic       ufe = 1'b1;
    logic [7:0] octet;
    logic       sof;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  phase_r9 = 1'b0;

    always #2 clk = ~clk;

    pcu_sync64_tx #(.FRAME_TYPE(FT)) u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .tick_i  (tick),
        .start_i (start),
        .tav_i   (tav),
        .ufe_i   (ufe),
        .octet_o (octet),
        .sof_o   (sof)
    );

    // ---------------- reference model ----------------
    bit         mbits [NBITS];
    int         m_idx, m_shown, m_seqn;
    bit         m_run, m_pend, m_tick_last;
    logic [1:0] m_ptav, m_atav;
    logic       m_pufe, m_aufe;
    logic [7:0] m_oct;
    logic       m_sof;

    task automatic build_frame(input logic [1:0] tv, input logic uf,
                               input logic [7:0] sq);
        logic [7:0] cv;
        for (int p = 0; p < NBITS; p++) mbits[p] = 1'b1;
        for (int p = 0; p < 64; p++) mbits[p] = 1'b0;
        mbits[64] = 1'b1;
        cv = {FT, tv, uf};
        for (int k = 0; k < 8; k++) mbits[65 + k] = cv[7 - k];
        mbits[73] = ($countones(cv) % 2 == 0);
        for (int k = 0; k < 8; k++) mbits[74 + k] = sq[7 - k];
        mbits[128] = 1'b1;
        mbits[192] = 1'b1;
    endtask

    function automatic logic [7:0] oct_at(input int i);
        logic [7:0] r;
        for (int j = 0; j < 8; j++) r[7 - j] = mbits[8 * i + j];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_shown = 0; m_seqn = 0;
            m_run = 0; m_pend = 0; m_tick_last = 0;
            m_ptav = 2'b00; m_atav = 2'b00; m_pufe = 1; m_aufe = 1;
            m_oct = 8'hFF; m_sof = 1'b0;
        end else begin
            m_tick_last = tick;
            m_sof = 1'b0;
            if (tick) begin
                if (m_idx == 0) begin
                    if (m_run || m_pend) begin
                        if (m_pend) begin
                            m_atav = m_ptav; m_aufe = m_pufe; m_pend = 0;
                        end
                        build_frame(m_atav, m_aufe, m_seqn[7:0]);
                        m_seqn = (m_seqn + 1) % 256;
                        m_run = 1; m_sof = 1'b1; m_shown = 0;
                        m_oct = oct_at(0); m_idx = 1;
                    end else begin
                        m_oct = 8'hFF;
                    end
                end else begin
                    m_shown = m_idx;
                    m_oct = oct_at(m_idx);
                    m_idx = (m_idx + 1) % NOCT;
                end
            end
            if (start) begin
                m_pend = 1; m_ptav = tav; m_pufe = ufe;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    function automatic string tagf();
        if (phase_r9)            return "R9 octet";
        if (!m_run)              return "R8 idle octet";
        if (!m_tick_last)        return "R6 hold octet";
        if (m_shown < 8)         return "R1 sync octet";
        if (m_shown == 8)        return "R2 control octet";
        if (m_shown == 9)        return "R3 parity/C8 octet";
        if (m_shown == 10)       return "R4 sequence octet";
        return "R5 filler octet";
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(octet === m_oct, tagf(), octet, m_oct);
            chk(sof === m_sof, "R7 sof", {7'b0, sof}, {7'b0, m_sof});
        end
    end

    // ---------------- stimulus ----------------
    task automatic tk(input int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic req(input logic [1:0] tv, input logic uf);
        @(negedge clk);
        start = 1'b1; tav = tv; ufe = uf;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(octet === 8'hFF, "R10 reset octet", octet, 8'hFF);
        chk(sof === 1'b0, "R10 reset sof", {7'b0, sof}, 8'h00);
        rst_n = 1'b1;

        tk(3);                       // idle, no request yet (R8)
        req(2'b01, 1'b1);
        tk(2 * NOCT);                // two frames back to back

        tk(50);                      // mid-frame requests (R9)
        phase_r9 = 1'b1;
        req(2'b10, 1'b0);
        tk(20);
        req(2'b00, 1'b0);            // latest wins
        tk(90);
        tk(NOCT);
        phase_r9 = 1'b0;

        // request in the same cycle as a boundary tick (R9)
        @(negedge clk);
        tick = 1'b1; start = 1'b1; tav = 2'b01; ufe = 1'b1;
        @(negedge clk);
        tick = 1'b0; start = 1'b0;
        tk(NOCT - 1 + NOCT);

        tk(NOCT * 256);              // sequence wrap (R4)

        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R6 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule